// File: doc/BRIEF.md
# Key-Unlocked Configuration Write Guard

This block holds a small bank of configuration registers on a plain register bus: address, write data, write strobe, read strobe and registered read data. A single write-enable flag decides whether writes reach the configuration registers. Once the flag is cleared, firmware that runs wild cannot change the configuration. The flag itself can only be changed after software writes two fixed key values to the protection control register, one after the other. Two indirect-access registers, an indirect control register and an indirect address/data register, accept writes whatever the flag says, so that indirect accesses keep working while protection is active.

The unlock lasts for exactly one write. The next write to any address relocks the control register. If that write goes to the control register, its bit 15 becomes the new write-enable value. If it goes anywhere else, the write-enable value stays as it was. Writes that protection blocks are dropped without an error. The `write_blocked` output gives a one-cycle pulse for each dropped write. The bus has no back-pressure: each strobe is taken in the cycle it is high.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset the write-enable bit (control register bit 15) is 1 and the key-status bits (bit 1 for key 2, bit 0 for key 1) are 0, so the control register at address 0 reads 16'h8000, and every data register reads 0.
- R2: While locked, a write of 16'h5341 to the control register sets the key-1 status bit (bit 0).
- R3: With key 1 accepted, a write of 16'h535A to the control register sets the key-2 status bit (bit 1), and the register is then unlocked, reading both status bits as 1.
- R4: With key 1 accepted, a control-register write of any value other than 16'h535A returns the block to locked, with both status bits reading 0.
- R5: With key 1 accepted, a write to any other address returns the block to locked and clears the key-1 status bit.
- R6: Reads of any address, including the control register, do not change the unlock state.
- R7: While unlocked, a control-register write copies its bit 15 into the write-enable bit and relocks the register (status bits read 0).
- R8: While unlocked, a write to any other address relocks the register and leaves the write-enable bit unchanged.
- R9: While the write-enable bit is 0, writes to data registers other than the two indirect-access registers leave them unchanged, and `write_blocked` is high for the one cycle after each such write.
- R10: The indirect control register (address 6) and the indirect address/data register (address 7) accept writes whatever the write-enable value.
- R11: While locked, a control-register write of any value other than key 1 has no effect: the write-enable bit and the status bits keep their values.
- R12: Reads are always permitted. `bus_rdata` holds the addressed register one cycle after `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address for a read or a write |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe, one read per high cycle |
| bus_rdata | output | 16 | Registered read data |
| write_blocked | output | 1 | One-cycle pulse after a write that protection dropped |

## Verification
A wrong unlock state shows at the ports as soon as the control register is next read: the status bits read back on the following cycle. It also shows at the next unlock-and-write attempt, as a write-enable value that does not change or changes when it should not. A wrong write-enable value or wrong gating shows one cycle after the faulty write: `write_blocked` pulses, or fails to pulse, against the bench model. A read of the target register then shows whether the data landed. The bench interleaves key writes, stray writes and reads at random, so an error in one state propagates into later expected values and is reported there.

// File: rtl/cfgprot_pkg.sv
package cfgprot_pkg;
  localparam int CP_DATA_W = 16;
  localparam logic [CP_DATA_W-1:0] CP_KEY_FIRST  = 16'h5341;
  localparam logic [CP_DATA_W-1:0] CP_KEY_SECOND = 16'h535A;
  localparam int CP_WREN_BIT = 15;
  localparam int CP_KEY2_BIT = 1;
  localparam int CP_KEY1_BIT = 0;

  typedef enum logic [1:0] {
    UL_LOCKED = 2'd0,
    UL_KEY1   = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_st_t;
endpackage

// File: rtl/cfgprot_unlock_fsm.sv
module cfgprot_unlock_fsm
  import cfgprot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 ctrl_sel,
  input  logic [CP_DATA_W-1:0] wdata,
  output logic [CP_DATA_W-1:0] ctrl_word
);
  unlock_st_t st_q;
  logic       wren_q;
  logic       key1_hit, key2_hit;

  assign key1_hit = ctrl_sel && (wdata == CP_KEY_FIRST);
  assign key2_hit = ctrl_sel && (wdata == CP_KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= UL_LOCKED;
      wren_q <= 1'b1;
    end else if (wr_en) begin
      unique case (st_q)
        UL_LOCKED: if (key1_hit) st_q <= UL_KEY1;
        UL_KEY1:   st_q <= key2_hit ? UL_OPEN : UL_LOCKED;
        UL_OPEN: begin
          st_q <= UL_LOCKED;
          if (ctrl_sel) wren_q <= wdata[CP_WREN_BIT];
        end
        default:   st_q <= UL_LOCKED;
      endcase
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CP_WREN_BIT] = wren_q;
    ctrl_word[CP_KEY2_BIT] = (st_q == UL_OPEN);
    ctrl_word[CP_KEY1_BIT] = (st_q != UL_LOCKED);
  end

  AST_WREN_ONLY_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wren_q) |-> $past(st_q == UL_OPEN && wr_en && ctrl_sel)); // R7
  AST_KEY1_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == UL_KEY1 && wr_en && !key2_hit) |=> (st_q == UL_LOCKED)); // R4
  AST_OPEN_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == UL_OPEN && wr_en) |=> (st_q == UL_LOCKED)); // R8
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(st_q) && $stable(wren_q))); // R6
endmodule

// File: rtl/cfgprot_write_gate.sv
module cfgprot_write_gate #(
  parameter int ADDR_W        = 3,
  parameter int CTRL_ADDR     = 0,
  parameter int IND_CTRL_ADDR = 6,
  parameter int IND_DATA_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wren,
  output logic              ctrl_sel,
  output logic              bank_we,
  output logic              write_blocked
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] IND_C  = ADDR_W'(IND_CTRL_ADDR);
  localparam logic [ADDR_W-1:0] IND_D  = ADDR_W'(IND_DATA_ADDR);

  logic exempt, blocked_now, blocked_q;

  assign ctrl_sel    = (addr == CTRL_A);
  assign exempt      = (addr == IND_C) || (addr == IND_D);
  assign blocked_now = wr_en && !ctrl_sel && !exempt && !wren;
  assign bank_we     = wr_en && !ctrl_sel && !blocked_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blocked_q <= 1'b0;
    else        blocked_q <= blocked_now;
  end
  assign write_blocked = blocked_q;

  AST_BLOCK_NEEDS_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |-> $past(wr_en && !wren)); // R9
endmodule

// File: rtl/cfgprot_regbank.sv
module cfgprot_regbank
  import cfgprot_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CP_DATA_W-1:0] wdata,
  input  logic                 rd_en,
  input  logic [CP_DATA_W-1:0] ctrl_word,
  output logic [CP_DATA_W-1:0] rdata
);
  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:0][CP_DATA_W-1:0] regs_q;
  logic [CP_DATA_W-1:0]           rdata_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == CTRL_ADDR) begin : g_ctrl_slot
      assign regs_q[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            regs_q[i] <= '0;
        else if (we && addr == ADDR_W'(i))     regs_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= (addr == ADDR_W'(CTRL_ADDR)) ? ctrl_word : regs_q[addr];
  end
  assign rdata = rdata_q;

  AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_q)); // R9
endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
  import cfgprot_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int CTRL_ADDR     = 0,
  parameter int IND_CTRL_ADDR = 6,
  parameter int IND_DATA_ADDR = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [CP_DATA_W-1:0] bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [CP_DATA_W-1:0] bus_rdata,
  output logic                 write_blocked
);
  logic                 ctrl_sel, bank_we;
  logic [CP_DATA_W-1:0] ctrl_word;

  cfgprot_write_gate #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .IND_CTRL_ADDR(IND_CTRL_ADDR), .IND_DATA_ADDR(IND_DATA_ADDR)
  ) gate_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wren(ctrl_word[CP_WREN_BIT]), .ctrl_sel(ctrl_sel),
    .bank_we(bank_we), .write_blocked(write_blocked)
  );

  cfgprot_unlock_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .ctrl_sel(ctrl_sel),
    .wdata(bus_wdata), .ctrl_word(ctrl_word)
  );

  cfgprot_regbank #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) bank_i (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .addr(bus_addr),
    .wdata(bus_wdata), .rd_en(bus_rd), .ctrl_word(ctrl_word), .rdata(bus_rdata)
  );

  AST_EXEMPT_ALWAYS_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADDR_W'(IND_CTRL_ADDR) || bus_addr == ADDR_W'(IND_DATA_ADDR)))
      |=> !write_blocked); // R10
endmodule

// File: tb/cfg_write_guard_tb_top.sv
`timescale 1ns/1ps
module cfg_write_guard_tb_top;
  localparam int AW = 3;
  localparam int NR = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0]   bus_rdata;
  logic          write_blocked;

  always #10 clk = ~clk;

  cfg_write_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .write_blocked(write_blocked)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // bench model: 0 locked, 1 key1, 2 open
  int          m_st = 0;
  logic        m_wren = 1'b1;
  logic [15:0] m_regs [NR];

  function automatic logic [15:0] exp_ctrl();
    return {m_wren, 13'd0, m_st == 2, m_st != 0};
  endfunction

  function automatic logic exp_blk(logic [AW-1:0] a);
    return (a != 0) && (a != 6) && (a != 7) && !m_wren;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(string req, logic [AW-1:0] a, logic [15:0] d);
    logic eb;
    eb = exp_blk(a);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(req, {15'd0, write_blocked}, {15'd0, eb});
    if (a == 0) begin
      case (m_st)
        0: if (d == 16'h5341) m_st = 1;
        1: m_st = (d == 16'h535A) ? 2 : 0;
        default: begin m_st = 0; m_wren = d[15]; end
      endcase
    end else begin
      m_st = (m_st == 1 || m_st == 2) ? 0 : m_st;
      if (!eb) m_regs[a] = d;
    end
  endtask

  task automatic do_read(string req, logic [AW-1:0] a);
    logic [15:0] e;
    e = (a == 0) ? exp_ctrl() : m_regs[a];
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, e);
  endtask

  task automatic unlock();
    do_write("R2", 0, 16'h5341);
    do_write("R3", 0, 16'h535A);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h1c0ffee;
    void'($urandom(seed));
    for (int i = 0; i < NR; i++) m_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    for (int i = 0; i < NR; i++) do_read("R1", AW'(i));
    check("R1", exp_ctrl(), 16'h8000);
    // R2 / R6: key 1, then reads do not disturb
    do_write("R2", 0, 16'h5341);
    do_read("R2", 0);
    check("R2", exp_ctrl(), 16'h8001);
    do_read("R6", 3);
    do_read("R6", 0);
    // R4: wrong second key
    do_write("R4", 0, 16'h1234);
    do_read("R4", 0);
    check("R4", exp_ctrl(), 16'h8000);
    // R5: other write aborts
    do_write("R5", 0, 16'h5341);
    do_write("R5", 2, 16'hAAAA);
    do_read("R5", 0);
    check("R5", exp_ctrl(), 16'h8000);
    // R3 + R7: unlock, clear WREN
    unlock();
    do_read("R3", 0);
    check("R3", exp_ctrl(), 16'h8003);
    do_write("R7", 0, 16'h0000);
    do_read("R7", 0);
    check("R7", exp_ctrl(), 16'h0000);
    // R9: blocked writes
    do_write("R9", 2, 16'h5555);
    do_read("R9", 2);
    check("R9", m_regs[2], 16'hAAAA);
    // R10: indirect regs always writable
    do_write("R10", 6, 16'h0606);
    do_write("R10", 7, 16'h0707);
    do_read("R10", 6);
    do_read("R10", 7);
    // R11: locked non-key control write ignored
    do_write("R11", 0, 16'h8000);
    do_read("R11", 0);
    check("R11", exp_ctrl(), 16'h0000);
    // R8: unlocked, other write relocks, WREN kept
    unlock();
    do_write("R8", 6, 16'h1111);
    do_read("R8", 0);
    check("R8", exp_ctrl(), 16'h0000);
    do_write("R9", 4, 16'h4444);
    // re-enable
    unlock();
    do_write("R7", 0, 16'h8000);
    do_read("R7", 0);
    do_write("R9", 4, 16'h4444);
    do_read("R9", 4);
    // random phase
    for (int k = 0; k < 600; k++) begin
      int unsigned r;
      logic [AW-1:0] a;
      logic [15:0] d;
      r = $urandom % 100;
      a = AW'($urandom % NR);
      if (($urandom % 3) == 0) a = 0;
      case ($urandom % 4)
        0: d = 16'h5341;
        1: d = 16'h535A;
        default: d = 16'($urandom);
      endcase
      if (r < 30) do_read("R12", a);
      else do_write("R9", a, d);
    end
    do_read("R12", 0);
    finish_run();
  end
endmodule